// File: doc/BRIEF.md
# Converter Serial Port Mode Emulator

This block is a synthesizable, clock-accurate stand-in for the digital side of a 16-bit sampling converter's serial port. It is meant for verifying host controllers. The host drives three pins: convert-start, serial-in and serial clock. The block answers on a serial data line and on an output-enable that models the line's tri-state. A test environment supplies the converted word on a parallel input. There is no analog model, and no pin timing margins are modelled. All three pins pass through two-flop synchronizers, and all edges are detected in the system clock domain.

There is no configuration register. The levels of serial-in and serial clock at each convert-start rising edge pick the operating mode. In select mode, serial-in and convert-start act as active-low selects. In cascade mode, the serial path acts as a shift register so that several devices can be chained. The same levels decide whether a low start bit leads the data. In select mode that choice is made by the select levels at the moment the conversion ends.

After a parameterized conversion time, the block captures the word and shifts it out MSB first, advancing one bit on each serial clock falling edge.

Top module: `adcport_emu`

## Requirements
- R1: After reset, and whenever no conversion has been started since reset, `sdoOe` and `sdoOut` are both low.
- R2: At a `cnvIn` rising edge, `sdiIn` high selects select mode and `sdiIn` low selects cascade mode. In cascade mode `sdoOe` is high from that edge onward, and `sdoOut` is low while the conversion runs.
- R3: A conversion lasts exactly `CONV_CYCLES` system clocks and cannot be restarted. Further `cnvIn` rising edges during it are ignored. `resultIn` is sampled at the moment the timer expires.
- R4: In select mode `sdoOe` stays low for the whole conversion, whatever `cnvIn` and `sdiIn` do.
- R5: Select mode without start bit applies when `cnvIn` and `sdiIn` are both high as the conversion ends. Once either of them goes low, `sdoOut` shows D15. Each serial clock falling edge taken while selected advances one bit. `sdoOe` drops after the 16th falling edge.
- R6: Select mode with start bit applies when `cnvIn` or `sdiIn` is low as the conversion ends. `sdoOe` rises at the end of the conversion with `sdoOut` low. Falling edges 1 to 16 present D15 to D0, and the 17th falling edge releases the line.
- R7: In select mode, deselecting (both `cnvIn` and `sdiIn` high) releases the line at once. It then stays released until the next conversion, even if the host selects again.
- R8: Cascade mode without start bit applies when `sckIn` is low at the `cnvIn` rising edge. After the conversion `sdoOut` shows D15, and each falling edge shifts one bit out. Each level sampled from `sdiIn` at a falling edge reappears on `sdoOut` after 16 falling edges.
- R9: Cascade mode with start bit applies when `sckIn` is high at the `cnvIn` rising edge. After the conversion, and until the first falling edge, `sdoOut` follows `sdiIn`, which passes the ready flag down the chain. Falling edges 1 to 16 then present D15 to D0, and a level sampled from `sdiIn` reappears after 17 falling edges.
- R10: The word is sent as plain straight binary, unchanged from `resultIn`, including the codes 0x0000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnvIn | input | 1 | Convert-start pin; also an active-low select in select mode |
| sdiIn | input | 1 | Serial-in pin; picks the mode at convert-start, select or cascade input afterwards |
| sckIn | input | 1 | Serial clock pin; its level at convert-start enables the cascade start bit |
| resultIn | input | WIDTH | Conversion word provided by the environment |
| sdoOut | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable of the serial data line (low means high impedance) |

## Verification
Several rules hold on every cycle and are checked there: the port is quiet before any conversion, the line is released throughout a select-mode conversion, a cascade-mode port always drives its line, conversions last exactly the programmed length, and a deselected select-mode port never drives. The following can only be shown by the bench's scenarios: the bit order on the wire, where the start bit sits, the count of falling edges before release, the 16- and 17-edge delays through the cascade, and the ready flag following serial-in. The bench also shows that a second convert-start cannot move the sampling instant, by changing the word after the real expiry and checking which word comes out.

// File: rtl/adcport_pkg.sv
package adcport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_READY = 2'd2
  } ctrlState_t;

  typedef enum logic [1:0] {
    SRC_TAP  = 2'd0,
    SRC_SDI  = 2'd1,
    SRC_ZERO = 2'd2
  } sdoSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;     // capture the word into the shifter
    logic    shift;    // advance one bit, taking serial-in at the bottom
    logic    tapLong;  // take the output from the start-bit position
    logic    drive;    // line enable
    sdoSrc_t src;      // output source select
  } dpStrobe_t;

endpackage

// File: rtl/adcport_sync.sv
module adcport_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : gBit
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipe <= '0;
        end else begin
          pipe <= {pipe[STAGES-2:0], din[gi]};
        end
      end
      assign lvl[gi] = pipe[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prv <= '0;
    else       prv <= lvl;
  end

endmodule

// File: rtl/adcport_ctrl.sv
module adcport_ctrl
  import adcport_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cnvLvl,
  input  logic       cnvPrv,
  input  logic       sdiLvl,
  input  logic       sdiPrv,
  input  logic       sckLvl,
  input  logic       sckPrv,
  output dpStrobe_t  strobe,
  output ctrlState_t stateOut,
  output logic       chainOut,
  output logic       selOut
);

  localparam int CNT_W = $clog2(WIDTH + 2);
  localparam int TMR_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_PLAIN = CNT_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] LAST_START = CNT_W'(WIDTH);
  localparam logic [TMR_W-1:0] TMR_LOAD   = TMR_W'(CONV_CYCLES - 1);

  ctrlState_t       state;
  logic             chainMode;
  logic             busyEn;
  logic             xferDone;
  logic             started;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] fallCnt;

  logic cnvRise, sckFall, selNow, selDrop, shiftOk, timerEnd;
  logic [CNT_W-1:0] lastIdx;

  assign cnvRise  = cnvLvl & ~cnvPrv;
  assign sckFall  = ~sckLvl & sckPrv;
  assign selNow   = ~(cnvLvl & sdiLvl);
  assign selDrop  = (cnvLvl & sdiLvl) & ~(cnvPrv & sdiPrv);
  assign timerEnd = (state == ST_CONV) && (timer == '0);
  assign lastIdx  = busyEn ? LAST_START : LAST_PLAIN;
  assign shiftOk  = (state == ST_READY) && sckFall &&
                    (chainMode || (selNow && !xferDone));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chainMode <= 1'b0;
      busyEn    <= 1'b0;
      xferDone  <= 1'b0;
      started   <= 1'b0;
      timer     <= '0;
      fallCnt   <= '0;
    end else if (cnvRise && state != ST_CONV) begin
      state     <= ST_CONV;
      chainMode <= ~sdiLvl;
      busyEn    <= sckLvl;
      timer     <= TMR_LOAD;
      xferDone  <= 1'b0;
      started   <= 1'b0;
      fallCnt   <= '0;
    end else begin
      case (state)
        ST_CONV: begin
          if (timerEnd) begin
            state <= ST_READY;
            if (!chainMode) busyEn <= selNow;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_READY: begin
          if (shiftOk) begin
            started <= 1'b1;
            if (fallCnt != '1) fallCnt <= fallCnt + 1'b1;
            if (!chainMode && fallCnt == lastIdx) xferDone <= 1'b1;
          end
          if (!chainMode && selDrop) xferDone <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.src     = SRC_ZERO;
    strobe.load    = timerEnd;
    strobe.shift   = shiftOk;
    strobe.tapLong = busyEn;
    case (state)
      ST_CONV: begin
        strobe.drive = chainMode;
        strobe.src   = SRC_ZERO;
      end
      ST_READY: begin
        if (chainMode) begin
          strobe.drive = 1'b1;
          strobe.src   = (busyEn && !started) ? SRC_SDI : SRC_TAP;
        end else begin
          strobe.drive = selNow && !xferDone;
          strobe.src   = SRC_TAP;
        end
      end
      default: ;
    endcase
  end

  assign stateOut = state;
  assign chainOut = chainMode;
  assign selOut   = selNow;

endmodule

// File: rtl/adcport_data.sv
module adcport_data
  import adcport_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] resultIn,
  input  logic             sdiLvl,
  input  dpStrobe_t        strobe,
  output logic             sdo
);

  localparam int REG_W = WIDTH + 1;

  logic [REG_W-1:0] shreg;
  logic             tap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg <= '0;
    end else if (strobe.load) begin
      shreg <= {1'b0, resultIn};
    end else if (strobe.shift) begin
      shreg <= {shreg[REG_W-2:0], sdiLvl};
    end
  end

  assign tap = strobe.tapLong ? shreg[REG_W-1] : shreg[REG_W-2];

  always_comb begin
    case (strobe.src)
      SRC_TAP: sdo = tap;
      SRC_SDI: sdo = sdiLvl;
      default: sdo = 1'b0;
    endcase
  end

endmodule

// File: rtl/adcport_emu.sv
module adcport_emu
  import adcport_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cnvIn,
  input  logic             sdiIn,
  input  logic             sckIn,
  input  logic [WIDTH-1:0] resultIn,
  output logic             sdoOut,
  output logic             sdoOe
);

  logic [2:0] pinLvl, pinPrv;
  dpStrobe_t  strobe;
  ctrlState_t ctrlState;
  logic       chainMode, selNow, dpSdo;

  adcport_sync #(.N(3), .STAGES(2)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({sckIn, sdiIn, cnvIn}),
    .lvl (pinLvl),
    .prv (pinPrv)
  );

  adcport_ctrl #(.WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cnvLvl  (pinLvl[0]),
    .cnvPrv  (pinPrv[0]),
    .sdiLvl  (pinLvl[1]),
    .sdiPrv  (pinPrv[1]),
    .sckLvl  (pinLvl[2]),
    .sckPrv  (pinPrv[2]),
    .strobe  (strobe),
    .stateOut(ctrlState),
    .chainOut(chainMode),
    .selOut  (selNow)
  );

  adcport_data #(.WIDTH(WIDTH)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .resultIn(resultIn),
    .sdiLvl  (pinLvl[1]),
    .strobe  (strobe),
    .sdo     (dpSdo)
  );

  assign sdoOe  = strobe.drive;
  assign sdoOut = strobe.drive & dpSdo;

endmodule

// File: rtl/adcport_check.sv
module adcport_check
  import adcport_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic       sdoOut,
  input logic       sdoOe,
  input ctrlState_t state,
  input logic       chainMode,
  input logic       selNow
);

  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] convCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 convCnt <= '0;
    else if (state != ST_CONV) convCnt <= '0;
    else                       convCnt <= convCnt + 1'b1;
  end

  // R1: idle port is silent
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!sdoOe && !sdoOut));

  // R2: cascade mode always drives the line
  assert_chain_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && chainMode) |-> sdoOe);

  // R3: conversion keeps running until its full length
  assert_conv_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && convCnt < CONV_LAST) |=> (state == ST_CONV));

  // R3: conversion ends exactly at its full length
  assert_conv_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && convCnt == CONV_LAST) |=> (state == ST_READY));

  // R4: select-mode line released while converting
  assert_cs_hiz_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && !chainMode) |-> !sdoOe);

  // R7: deselected select-mode port never drives
  assert_sel_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && !chainMode && !selNow) |-> !sdoOe);

endmodule

bind adcport_emu adcport_check #(.WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES)) uCheck (
  .clk      (clk),
  .rstN     (rstN),
  .sdoOut   (sdoOut),
  .sdoOe    (sdoOe),
  .state    (ctrlState),
  .chainMode(chainMode),
  .selNow   (selNow)
);

// File: tb/adcport_emu_test.sv
module adcport_emu_test;

  localparam int W  = 16;
  localparam int CC = 40;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cnv = 1'b0;
  logic         sdi = 1'b0;
  logic         sck = 1'b0;
  logic [W-1:0] res = '0;
  logic         sdoOut, sdoOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adcport_emu #(.WIDTH(W), .CONV_CYCLES(CC)) uut (
    .clk(clk), .rstN(rstN), .cnvIn(cnv), .sdiIn(sdi), .sckIn(sck),
    .resultIn(res), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sckPulse();
    sck = 1'b1; waitClk(5);
    sck = 1'b0; waitClk(5);
  endtask

  // expected select-mode bit after n falling edges
  function automatic logic expCs(input logic [W-1:0] d, input bit startBit, input int n);
    if (startBit) return (n == 0) ? 1'b0 : d[W-n];
    return d[W-1-n];
  endfunction

  // expected cascade bit after n falling edges (n >= 1 when startBit)
  function automatic logic expChain(input logic [W-1:0] d, input bit startBit,
                                    input logic [63:0] pat, input int n);
    if (startBit) return (n <= W) ? d[W-n] : pat[n-W-1];
    return (n < W) ? d[W-1-n] : pat[n-W];
  endfunction

  // three-wire select mode: convert-start is the select, serial-in held high
  task automatic csThree(input logic [W-1:0] d, input bit startBit, input string tag);
    res = d; sdi = 1'b1; waitClk(5);
    cnv = 1'b1; waitClk(4);
    if (startBit) cnv = 1'b0;
    waitClk(2);
    chk("R4 line released during conversion", sdoOe, 0);
    waitClk(CC + 4);
    if (!startBit) begin
      chk("R5 no drive before select", sdoOe, 0);
      cnv = 1'b0; waitClk(5);
    end
    for (int n = 0; n < (startBit ? W + 1 : W); n++) begin
      chk(startBit ? "R6 enable" : "R5 enable", sdoOe, 1);
      chk(tag, sdoOut, expCs(d, startBit, n));
      sckPulse();
    end
    chk(startBit ? "R6 release after 17th edge" : "R5 release after 16th edge", sdoOe, 0);
  endtask

  // four-wire select mode with start bit: serial-in is the select
  task automatic csFour(input logic [W-1:0] d);
    res = d; cnv = 1'b0; sdi = 1'b1; waitClk(5);
    cnv = 1'b1; waitClk(4);
    sdi = 1'b0; waitClk(2);
    chk("R4 line released while selected in conversion", sdoOe, 0);
    waitClk(CC + 4);
    for (int n = 0; n <= W; n++) begin
      chk("R6 four-wire enable", sdoOe, 1);
      chk("R6 four-wire bit", sdoOut, expCs(d, 1'b1, n));
      sckPulse();
    end
    chk("R6 four-wire release", sdoOe, 0);
    sdi = 1'b1; waitClk(5);
    cnv = 1'b0; waitClk(5);
  endtask

  // cascade mode, optional start bit chosen by serial clock level
  task automatic chainRun(input logic [W-1:0] d, input bit startBit, input logic [63:0] pat);
    res = d; cnv = 1'b0; sdi = 1'b0; sck = startBit; waitClk(5);
    cnv = 1'b1; waitClk(5);
    sck = 1'b0; waitClk(3);
    chk("R2 cascade drives during conversion", sdoOe, 1);
    chk("R2 cascade low during conversion", sdoOut, 0);
    waitClk(CC + 4);
    if (startBit) begin
      sdi = 1'b0; waitClk(5);
      chk("R9 ready flag follows serial-in low", sdoOut, 0);
      sdi = 1'b1; waitClk(5);
      chk("R9 ready flag follows serial-in high", sdoOut, 1);
    end
    for (int n = 0; n < (startBit ? 2 * W + 1 : 2 * W); n++) begin
      sdi = pat[n]; waitClk(5);
      if (startBit && n == 0)
        chk("R9 before first edge", sdoOut, pat[0]);
      else
        chk(startBit ? "R9 cascade bit" : "R8 cascade bit", sdoOut, expChain(d, startBit, pat, n));
      chk("R2 cascade enable", sdoOe, 1);
      sckPulse();
    end
    cnv = 1'b0; sdi = 1'b0; waitClk(5);
  endtask

  // early deselect in four-wire select mode without start bit
  task automatic earlyRelease(input logic [W-1:0] d);
    res = d; cnv = 1'b0; sdi = 1'b1; waitClk(5);
    cnv = 1'b1; waitClk(CC + 8);
    chk("R7 no drive before select", sdoOe, 0);
    sdi = 1'b0; waitClk(5);
    for (int n = 0; n < 5; n++) begin
      chk("R5 four-wire bit", sdoOut, expCs(d, 1'b0, n));
      sckPulse();
    end
    sdi = 1'b1; waitClk(5);
    chk("R7 deselect releases", sdoOe, 0);
    sdi = 1'b0; waitClk(5);
    chk("R7 reselect stays released", sdoOe, 0);
    sckPulse();
    chk("R7 still released after edge", sdoOe, 0);
    sdi = 1'b1; waitClk(5);
    cnv = 1'b0; waitClk(5);
  endtask

  // second convert-start inside a conversion must not move sampling
  task automatic noRestart(input logic [W-1:0] a, input logic [W-1:0] b);
    res = a; sdi = 1'b1; cnv = 1'b0; waitClk(5);
    cnv = 1'b1; waitClk(4);
    cnv = 1'b0; waitClk(1);
    chk("R4 released with select low in conversion", sdoOe, 0);
    waitClk(1);
    cnv = 1'b1; waitClk(39);
    res = b; waitClk(10);
    cnv = 1'b0; waitClk(5);
    for (int n = 0; n < W; n++) begin
      chk("R3 word sampled at first expiry", sdoOut, expCs(a, 1'b0, n));
      sckPulse();
    end
    chk("R3 release after word", sdoOe, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    waitClk(3);
    chk("R1 enable in reset", sdoOe, 0);
    chk("R1 data in reset", sdoOut, 0);
    rstN = 1'b1;
    waitClk(4);
    chk("R1 enable after reset", sdoOe, 0);
    sck = 1'b1; waitClk(5); sck = 1'b0; sdi = 1'b1; waitClk(5);
    chk("R1 still quiet without conversion", sdoOe, 0);

    csThree(16'h0000, 1'b0, "R10 zero code");
    csThree(16'hFFFF, 1'b0, "R10 full code");
    csThree(16'hA5C3, 1'b1, "R6 three-wire bit");
    csFour(16'h3C5A);
    earlyRelease(16'hB2E1);
    noRestart(16'h1234, 16'hEDCB);
    chainRun(16'hC0DE, 1'b0, 64'h0000_0000_9A3F_17C5);
    chainRun(16'h7E81, 1'b1, 64'h0000_0000_4F0B_E2D6);

    for (int it = 0; it < 20; it++) begin
      logic [W-1:0] d;
      logic [63:0]  pat;
      int           mode;
      d    = W'($urandom);
      pat  = {$urandom, $urandom};
      mode = int'($urandom % 5);
      case (mode)
        0: csThree(d, 1'b0, "R5 random bit");
        1: csThree(d, 1'b1, "R6 random bit");
        2: csFour(d);
        3: chainRun(d, 1'b0, pat);
        default: chainRun(d, 1'b1, pat);
      endcase
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule